// File: doc/BRIEF.md
# Dual 16-bit Timer Core with Chaining Control

This block holds two 16-bit up-counters, a low counter and a high counter, and one 16-bit control register that governs both of them. For each counter the register provides a run enable, a one-shot software zeroing request and an enable that lets a per-counter external zeroing input act. Each counter advances by one on every clock in which its tick input is high and its run enable is set.

One control bit joins the two counters into a single 32-bit counter. In that mode the high counter ignores its own tick and advances only on the carry out of the low counter. The low counter's external zeroing input is then disregarded. A status output reports the chained mode, because a capture/compare unit that shares these counters may only capture while the counters are joined. Several register fields, for edge selection, one-shot and count direction, are stored and read back but drive no logic.

Top module: `dual_tmr_ctl`

## Requirements
- R1: After reset the register reads 0x0000, both counters read 0, and both wrap pulses and the chain status output are low.
- R2: A write stores every register bit except bit 14 and bit 6, which always read as 0. The inert fields in bits 11..7 and 3..0 read back exactly as written. The register is visible on rd_data from the clock edge that takes the write.
- R3: A write with bit 6 set (low counter) or bit 14 set (high counter) forces that counter to 0 at the same clock edge, with no increment in that cycle.
- R4: With bit 5 (low) or bit 13 (high) set, a counter increments by one at each edge where its tick input is high. With the bit clear, the counter holds its value.
- R5: With bit 4 (low) or bit 12 (high) set, a high level on that counter's external clear input forces the counter to 0 at the next edge. With the bit clear, the input has no effect.
- R6: With bit 15 set, the high counter ignores tick_hi. It increments, if bit 13 is set, exactly at the edge where the low counter advances from 0xFFFF to 0x0000.
- R7: With bit 15 set, xclr_lo has no effect on the low counter. The high counter still obeys xclr_hi under bit 12.
- R8: capture_only is high exactly while bit 15 of the register is set.
- R9: When a counter advances from 0xFFFF to 0x0000, its wrap output is high for exactly the one cycle in which the counter reads 0x0000.
- R10: A software and an external clear in the same cycle leave the counter at 0, with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| tick_lo | input | 1 | Count tick for the low counter |
| tick_hi | input | 1 | Count tick for the high counter (unused when chained) |
| xclr_lo | input | 1 | External clear request for the low counter |
| xclr_hi | input | 1 | External clear request for the high counter |
| cnt_lo | output | 16 | Low counter value |
| cnt_hi | output | 16 | High counter value |
| ovf_lo | output | 1 | One-cycle wrap pulse of the low counter |
| ovf_hi | output | 1 | One-cycle wrap pulse of the high counter (32-bit wrap when chained) |
| capture_only | output | 1 | Chained mode is active; capture-only restriction applies |

## Verification
The assertions check on every cycle that software clears take effect at once and read back as zero, that disabled counters hold, and that chaining freezes the high counter unless the low counter is at its top value. They also check that a masked low external clear cannot zero the low counter and that a wrap pulse always coincides with a zero count. Only the bench scenarios show exact count values across sequences, that inert fields are stored, and that an external clear is ignored while its enable is off. Only a full 65536-tick run shows the carry into the high counter and the wrap pulses actually firing.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int REG_W       = 16;
  localparam int CNT_W       = 16;
  // control field positions (software decodes these)
  localparam int B_CHAIN     = 15;
  localparam int B_SCLR_HI   = 14;
  localparam int B_RUN_HI    = 13;
  localparam int B_XEN_HI    = 12;
  localparam int B_SCLR_LO   = 6;
  localparam int B_RUN_LO    = 5;
  localparam int B_XEN_LO    = 4;

  // value kept in the register for a given write: clear requests do not persist
  function automatic logic [REG_W-1:0] store_value(input logic [REG_W-1:0] d);
    logic [REG_W-1:0] m;
    m = d;
    m[B_SCLR_HI] = 1'b0;
    m[B_SCLR_LO] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/dtc_ctrl_reg.sv
module dtc_ctrl_reg
  import dtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic             sclr_lo_req,
  output logic             sclr_hi_req
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= store_value(wr_data);
  end

  // clear requests act at the same edge as the write
  assign sclr_lo_req = wr_en & wr_data[B_SCLR_LO];
  assign sclr_hi_req = wr_en & wr_data[B_SCLR_HI];
endmodule

// File: rtl/dtc_event_sel.sv
module dtc_event_sel (
  input  logic chain,
  input  logic run_lo,
  input  logic run_hi,
  input  logic xen_lo,
  input  logic xen_hi,
  input  logic sclr_lo_req,
  input  logic sclr_hi_req,
  input  logic tick_lo,
  input  logic tick_hi,
  input  logic xclr_lo,
  input  logic xclr_hi,
  input  logic carry_lo,
  output logic clr_lo,
  output logic clr_hi,
  output logic inc_lo,
  output logic inc_hi
);
  logic xhit_lo, xhit_hi, adv_hi;

  // chained mode masks the low external clear
  assign xhit_lo = xclr_lo & xen_lo & ~chain;
  assign xhit_hi = xclr_hi & xen_hi;

  assign clr_lo  = sclr_lo_req | xhit_lo;
  assign clr_hi  = sclr_hi_req | xhit_hi;

  assign adv_hi  = chain ? carry_lo : tick_hi;

  assign inc_lo  = run_lo & tick_lo & ~clr_lo;
  assign inc_hi  = run_hi & adv_hi & ~clr_hi;
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         carry,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] next_val(input logic [W-1:0] c,
                                            input logic cl, input logic in);
    if (cl)      return '0;
    else if (in) return c + 1'b1;
    else         return c;
  endfunction

  assign carry = inc & (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= next_val(cnt, clr, inc);
      ovf <= carry;
    end
  end
endmodule

// File: rtl/dual_tmr_ctl.sv
module dual_tmr_ctl
  import dtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tick_lo,
  input  logic             tick_hi,
  input  logic             xclr_lo,
  input  logic             xclr_hi,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             ovf_lo,
  output logic             ovf_hi,
  output logic             capture_only
);
  logic [REG_W-1:0] ctrl_q;
  logic sclr_lo_req, sclr_hi_req;
  logic clr_lo, clr_hi, inc_lo, inc_hi, carry_lo, carry_hi;

  dtc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .sclr_lo_req(sclr_lo_req), .sclr_hi_req(sclr_hi_req)
  );

  dtc_event_sel u_sel (
    .chain(ctrl_q[B_CHAIN]),
    .run_lo(ctrl_q[B_RUN_LO]), .run_hi(ctrl_q[B_RUN_HI]),
    .xen_lo(ctrl_q[B_XEN_LO]), .xen_hi(ctrl_q[B_XEN_HI]),
    .sclr_lo_req(sclr_lo_req), .sclr_hi_req(sclr_hi_req),
    .tick_lo(tick_lo), .tick_hi(tick_hi),
    .xclr_lo(xclr_lo), .xclr_hi(xclr_hi),
    .carry_lo(carry_lo),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .inc_lo(inc_lo), .inc_hi(inc_hi)
  );

  dtc_counter #(.W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr_lo), .inc(inc_lo),
    .cnt(cnt_lo), .carry(carry_lo), .ovf(ovf_lo)
  );

  dtc_counter #(.W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr_hi), .inc(inc_hi),
    .cnt(cnt_hi), .carry(carry_hi), .ovf(ovf_hi)
  );

  logic unused_carry_hi;
  assign unused_carry_hi = carry_hi;

  assign rd_data      = ctrl_q;
  assign capture_only = ctrl_q[B_CHAIN];
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             xclr_lo,
  input logic             xclr_hi,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic             ovf_lo,
  input logic             ovf_hi,
  input logic             capture_only
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_sclr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_SCLR_LO] && !rd_data[B_SCLR_HI]);

  p_sclr_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_SCLR_LO]) |=> (cnt_lo == '0));

  p_sclr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_SCLR_HI]) |=> (cnt_hi == '0));

  p_hold_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[B_RUN_LO] && !(wr_en && wr_data[B_SCLR_LO]) &&
     !(xclr_lo && rd_data[B_XEN_LO] && !rd_data[B_CHAIN])) |=> $stable(cnt_lo));

  p_hold_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[B_RUN_HI] && !(wr_en && wr_data[B_SCLR_HI]) &&
     !(xclr_hi && rd_data[B_XEN_HI])) |=> $stable(cnt_hi));

  p_chain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_CHAIN] && cnt_lo != TOP && !(wr_en && wr_data[B_SCLR_HI]) &&
     !(xclr_hi && rd_data[B_XEN_HI])) |=> $stable(cnt_hi));

  p_lo_xclr_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_CHAIN] && xclr_lo && cnt_lo != '0 && cnt_lo != TOP &&
     !(wr_en && wr_data[B_SCLR_LO])) |=> (cnt_lo != '0));

  p_chain_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_only) |-> $past(wr_en && wr_data[B_CHAIN]));

  p_wrap_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |-> (cnt_lo == '0));

  p_wrap_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi |-> (cnt_hi == '0));

  p_wrap_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |=> !ovf_lo);
endmodule

bind dual_tmr_ctl dtc_checker u_chk (.*);

// File: tb/dual_tmr_ctl_tb_top.sv
module dual_tmr_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic tick_lo = 1'b0, tick_hi = 1'b0, xclr_lo = 1'b0, xclr_hi = 1'b0;
  logic [15:0] rd_data, cnt_lo, cnt_hi;
  logic ovf_lo, ovf_hi, capture_only;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_tmr_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_lo(tick_lo), .tick_hi(tick_hi), .xclr_lo(xclr_lo), .xclr_hi(xclr_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
    .capture_only(capture_only)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] wd;
    logic        tl, th, xl, xh;
    logic [15:0] elo, ehi, erd;
  } vec_t;

  // expected values hold after the one edge that takes each vector
  localparam vec_t VECS [14] = '{
    '{1'b1, 16'h2020, 1'b0,1'b0,1'b0,1'b0, 16'd0, 16'd0, 16'h2020}, // run both
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0, 16'd1, 16'd1, 16'h2020}, // R4
    '{1'b0, 16'h0000, 1'b1,1'b0,1'b0,1'b0, 16'd2, 16'd1, 16'h2020},
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0, 16'd3, 16'd2, 16'h2020},
    '{1'b0, 16'h0000, 1'b0,1'b0,1'b1,1'b1, 16'd3, 16'd2, 16'h2020}, // R5 ignored
    '{1'b1, 16'h3030, 1'b0,1'b0,1'b0,1'b0, 16'd3, 16'd2, 16'h3030},
    '{1'b0, 16'h0000, 1'b1,1'b0,1'b1,1'b0, 16'd0, 16'd2, 16'h3030}, // R5 clear
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0, 16'd1, 16'd3, 16'h3030},
    '{1'b1, 16'h3070, 1'b1,1'b0,1'b0,1'b0, 16'd0, 16'd3, 16'h3030}, // R3
    '{1'b1, 16'h3070, 1'b1,1'b1,1'b1,1'b0, 16'd0, 16'd4, 16'h3030}, // R10
    '{1'b1, 16'h1010, 1'b1,1'b1,1'b0,1'b0, 16'd1, 16'd5, 16'h1010},
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0, 16'd1, 16'd5, 16'h1010}, // R4 hold
    '{1'b1, 16'h4000, 1'b0,1'b0,1'b0,1'b0, 16'd1, 16'd0, 16'h0000}, // R3 hi
    '{1'b1, 16'h0F8F, 1'b1,1'b1,1'b0,1'b0, 16'd1, 16'd0, 16'h0F8F}  // R2 inert
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [15:0] wd,
                       input logic tl, input logic th, input logic xl, input logic xh);
    wr_en = we; wr_data = wd; tick_lo = tl; tick_hi = th; xclr_lo = xl; xclr_hi = xh;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tick_lo = 1'b0; tick_hi = 1'b0; xclr_lo = 1'b0; xclr_hi = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rd", {16'h0, rd_data}, 32'h0);
    chk("R1 cnt", {cnt_hi, cnt_lo}, 32'h0);
    chk("R1 flags", {29'h0, ovf_lo, ovf_hi, capture_only}, 32'h0);

    for (int i = 0; i < 14; i++) begin
      drive(VECS[i].we, VECS[i].wd, VECS[i].tl, VECS[i].th, VECS[i].xl, VECS[i].xh);
      chk($sformatf("R2/R3/R4/R5/R10 vec %0d lo", i), {16'h0, cnt_lo}, {16'h0, VECS[i].elo});
      chk($sformatf("R2/R3/R4/R5/R10 vec %0d hi", i), {16'h0, cnt_hi}, {16'h0, VECS[i].ehi});
      chk($sformatf("R2/R3/R4/R5/R10 vec %0d rd", i), {16'h0, rd_data}, {16'h0, VECS[i].erd});
    end

    // chained mode: carry, masked low clear, flag, wrap pulse
    do_reset();
    drive(1'b1, 16'hA030, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 flag on", {31'h0, capture_only}, 32'h1);
    for (int i = 0; i < 10; i++) drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 hi ignores tick_hi", {cnt_hi, cnt_lo}, {16'd0, 16'd10});
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 low clear masked", {16'h0, cnt_lo}, 32'd10);
    for (int i = 0; i < 65525; i++) drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 low at top", {cnt_hi, cnt_lo}, {16'd0, 16'hFFFF});
    chk("R9 no early wrap", {30'h0, ovf_lo, ovf_hi}, 32'h0);
    drive(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 carry into hi", {cnt_hi, cnt_lo}, {16'd1, 16'd0});
    chk("R9 wrap pulse lo", {30'h0, ovf_lo, ovf_hi}, 32'h2);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 pulse ends", {31'h0, ovf_lo}, 32'h0);
    drive(1'b1, 16'hB030, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 hi clear in chain", {16'h0, cnt_hi}, 32'h0);
    drive(1'b1, 16'h3030, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 flag off", {31'h0, capture_only}, 32'h0);

    // high counter wrap on its own tick
    do_reset();
    drive(1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 65535; i++) drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 hi at top", {16'h0, cnt_hi}, {16'h0, 16'hFFFF});
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 hi wraps", {15'h0, ovf_hi, cnt_hi}, {15'h0, 1'b1, 16'h0});
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 hi pulse ends", {31'h0, ovf_hi}, 32'h0);

    finish_run();
  end
endmodule